// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Controller

This block generates one pulse-width-modulated output for each of several channels. All channels count cycles of one shared reference clock. Each channel divides that clock in two stages: a prescaler sets the length of one step, and a divider sets how many steps make up a period. A high-time compare keeps the output high for a chosen number of steps at the start of each period. Software sees two 32-bit words per channel on a simple word-addressed bus. One word holds the high-time count and the divider. The other holds the enable, the commit request and the prescaler.

Writes only change a staging copy of the settings. Software asks for a commit by writing the control word with the commit bit set. The staged values, including the enable, then move into the active set. If the channel is running, this happens on the last cycle of the current period, so a period is never cut short. If the channel is stopped, it happens at once. The commit bit reads back as 1 until the move has happened. A stopped channel drives its output low and holds its counters at zero. A newly enabled channel starts a fresh period.

Top module: `pwm_bank`

## Requirements
- R1: Channel c, word n (n=0 timing word, n=1 control word) sits at byte address (c*2+n)*4. The timing word holds the high-time count in bits [31:16] and the divider in bits [15:0]. The control word holds the enable in bit 31, the commit bit in bit 30 and the prescaler in bits [15:0]. Accesses whose address bits [1:0] are not zero write nothing and read 0.
- R2: A running channel has a period of (prescaler+1)*(divider+1) reference cycles. Its output is high for the first high_time*(prescaler+1) cycles of each period.
- R3: A high-time count greater than the divider gives an output that stays high. A high-time count of zero gives an output that stays low.
- R4: Staged writes, including a change of the enable bit, do not change the output until a commit is requested.
- R5: On a running channel, a commit takes effect at the end of the current period. The commit bit reads 1 until then and 0 afterwards.
- R6: On a stopped channel, a commit takes effect on the next clock. A stopped channel drives its output low. A newly enabled channel starts at the beginning of a period.
- R7: Channels are independent: settings of one channel never change another channel's output.
- R8: Synchronous reset clears every staged and active setting, so all outputs are low and all words read 0.
- R9: A read returns the staged contents of the addressed word, with bits [29:16] of the control word reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 5 | Byte address (width follows the channel count) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
If the active settings are loaded at the wrong time, the first fault shows within one period of a commit. The output then switches to the new high time while the commit bit still reads 1, or it starts mid-period with the wrong first level. If a step or period counter wraps at the wrong point, the high-cycle count over two whole periods is wrong at once. The bench measures that count for several prescaler, divider and high-time combinations, including the constant-high and constant-low cases. If a staged value leaks into the active set, the output changes within a few cycles of a write that had no commit.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int unsigned FIELD_W  = 16;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned EN_POS   = 31;
    localparam int unsigned UPD_POS  = 30;
    localparam int unsigned HI_LSB   = 16;

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [WORD_W-1:0]  word_t;

    // One channel's settings, staged or active
    typedef struct packed {
        logic   en;
        field_t pre;
        field_t div;
        field_t hi;
    } chan_cfg_t;

    typedef enum logic {
        SEL_TIMING = 1'b0,
        SEL_CTRL   = 1'b1
    } word_sel_e;

    function automatic word_t pack_timing(input chan_cfg_t c);
        word_t w;
        w = '0;
        w[WORD_W-1:HI_LSB]  = c.hi;
        w[FIELD_W-1:0]      = c.div;
        return w;
    endfunction

    function automatic word_t pack_ctrl(input chan_cfg_t c, input logic pending);
        word_t w;
        w = '0;
        w[EN_POS]           = c.en;
        w[UPD_POS]          = pending;
        w[FIELD_W-1:0]      = c.pre;
        return w;
    endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int unsigned N_CH   = 4,
    parameter int unsigned ADDR_W = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  word_t                  bus_wdata,
    output word_t                  bus_rdata,
    input  logic [N_CH-1:0]        load_ack,
    output chan_cfg_t [N_CH-1:0]   stage_cfg,
    output logic [N_CH-1:0]        pending
);

    localparam int unsigned IDX_W = ADDR_W - 3;

    logic             aligned;
    logic [IDX_W-1:0] ch_idx;
    word_sel_e        sel;
    logic             idx_ok;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign ch_idx  = bus_addr[ADDR_W-1:3];
    assign sel     = word_sel_e'(bus_addr[2]);
    assign idx_ok  = aligned && (32'(ch_idx) < N_CH);

    for (genvar c = 0; c < N_CH; c++) begin : g_stage
        logic hit;
        assign hit = bus_we && idx_ok && (32'(ch_idx) == c);

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_cfg[c] <= '0;
                pending[c]   <= 1'b0;
            end else begin
                if (hit && sel == SEL_TIMING) begin
                    stage_cfg[c].hi  <= bus_wdata[WORD_W-1:HI_LSB];
                    stage_cfg[c].div <= bus_wdata[FIELD_W-1:0];
                end
                if (hit && sel == SEL_CTRL) begin
                    stage_cfg[c].en  <= bus_wdata[EN_POS];
                    stage_cfg[c].pre <= bus_wdata[FIELD_W-1:0];
                end
                // a fresh request wins over an acknowledge in the same cycle
                if (hit && sel == SEL_CTRL && bus_wdata[UPD_POS])
                    pending[c] <= 1'b1;
                else if (load_ack[c])
                    pending[c] <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (idx_ok && 32'(ch_idx) == c) begin
                if (sel == SEL_TIMING)
                    bus_rdata = pack_timing(stage_cfg[c]);
                else
                    bus_rdata = pack_ctrl(stage_cfg[c], pending[c]);
            end
        end
    end

endmodule

// File: rtl/pwm_bank_timebase.sv
module pwm_bank_timebase
    import pwm_bank_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   restart,
    input  field_t pre_lim,
    input  field_t div_lim,
    output field_t pre_cnt,
    output field_t div_cnt,
    output logic   last
);

    logic step_end;

    assign step_end = (pre_cnt == pre_lim);
    assign last     = run && step_end && (div_cnt == div_lim);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (step_end) begin
            pre_cnt <= '0;
            if (div_cnt == div_lim)
                div_cnt <= '0;
            else
                div_cnt <= div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  chan_cfg_t stage,
    input  logic      pending,
    output logic      load,
    output chan_cfg_t active,
    output field_t    pre_cnt,
    output field_t    div_cnt,
    output logic      pwm
);

    logic period_last;

    pwm_bank_timebase u_tb (
        .clk     (clk),
        .rst     (rst),
        .run     (active.en),
        .restart (load),
        .pre_lim (active.pre),
        .div_lim (active.div),
        .pre_cnt (pre_cnt),
        .div_cnt (div_cnt),
        .last    (period_last)
    );

    // commit at period end, or at once while stopped
    assign load = pending && (!active.en || period_last);

    always_ff @(posedge clk) begin
        if (rst)
            active <= '0;
        else if (load)
            active <= stage;
    end

    assign pwm = active.en && (div_cnt < active.hi);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int unsigned N_CH   = 4,
    localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int unsigned ADDR_W = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [N_CH-1:0]   pwm_out
);

    chan_cfg_t [N_CH-1:0] stage_w;
    chan_cfg_t [N_CH-1:0] act_w;
    logic [N_CH-1:0]      pend_w;
    logic [N_CH-1:0]      load_w;
    field_t [N_CH-1:0]    pre_cnt_w;
    field_t [N_CH-1:0]    div_cnt_w;

    pwm_bank_regs #(
        .N_CH   (N_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .load_ack  (load_w),
        .stage_cfg (stage_w),
        .pending   (pend_w)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        pwm_bank_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .stage   (stage_w[c]),
            .pending (pend_w[c]),
            .load    (load_w[c]),
            .active  (act_w[c]),
            .pre_cnt (pre_cnt_w[c]),
            .div_cnt (div_cnt_w[c]),
            .pwm     (pwm_out[c])
        );
    end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int unsigned N_CH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [N_CH-1:0]      pwm_out,
    input  chan_cfg_t [N_CH-1:0] act_w,
    input  logic [N_CH-1:0]      pend_w,
    input  logic [N_CH-1:0]      load_w,
    input  field_t [N_CH-1:0]    pre_cnt_w,
    input  field_t [N_CH-1:0]    div_cnt_w
);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        // R5
        pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (load_w[c] && !bus_we) |=> !pend_w[c]);

        // R4
        active_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !load_w[c] |=> $stable(act_w[c]));

        // R2
        count_bound_chk: assert property (@(posedge clk) disable iff (rst)
            act_w[c].en |-> (pre_cnt_w[c] <= act_w[c].pre && div_cnt_w[c] <= act_w[c].div));

        // R6
        idle_low_chk: assert property (@(posedge clk) disable iff (rst)
            !act_w[c].en |-> (!pwm_out[c] && pre_cnt_w[c] == '0 && div_cnt_w[c] == '0));

        // R3
        full_high_chk: assert property (@(posedge clk) disable iff (rst)
            (act_w[c].en && act_w[c].hi > act_w[c].div) |-> pwm_out[c]);

        // R3
        zero_low_chk: assert property (@(posedge clk) disable iff (rst)
            (act_w[c].hi == '0) |-> !pwm_out[c]);
    end

endmodule

bind pwm_bank pwm_bank_chk #(.N_CH(N_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .pwm_out   (pwm_out),
    .act_w     (act_w),
    .pend_w    (pend_w),
    .load_w    (load_w),
    .pre_cnt_w (pre_cnt_w),
    .div_cnt_w (div_cnt_w)
);

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm_bank dut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    // {prescaler, divider, high time}
    localparam logic [47:0] VEC [0:5] = '{
        {16'd0, 16'd3, 16'd2},
        {16'd2, 16'd4, 16'd1},
        {16'd1, 16'd5, 16'd0},
        {16'd0, 16'd2, 16'd5},
        {16'd3, 16'd0, 16'd1},
        {16'd4, 16'd9, 16'd9}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called just after a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input bit en, input bit upd, input logic [15:0] pre);
        return {en, upd, 14'd0, pre};
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8: reset state
        chk(pwm_out == 4'b0, "R8 outputs after reset", {28'd0, pwm_out}, 32'd0);
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), rv);
            chk(rv == 32'd0, "R8 word after reset", rv, 32'd0);
        end

        // R2 R3 R6 R7: table of settings on channel 0
        for (int v = 0; v < 6; v++) begin
            logic [15:0] pre, dv, hi;
            int n, heff, highs;
            bit first;
            pre = VEC[v][47:32];
            dv  = VEC[v][31:16];
            hi  = VEC[v][15:0];
            n    = (int'(pre) + 1) * (int'(dv) + 1);
            heff = (hi > dv) ? int'(dv) + 1 : int'(hi);
            wr(5'd0, {hi, dv});
            wr(5'd4, ctrl_word(1'b1, 1'b1, pre));
            highs = 0;
            first = 1'b0;
            for (int s = 0; s < 2 * n; s++) begin
                @(negedge clk);
                if (s == 0) first = pwm_out[0];
                if (pwm_out[0]) highs++;
            end
            chk(highs == 2 * heff * (int'(pre) + 1), "R2 R3 high cycles over two periods",
                highs, 2 * heff * (int'(pre) + 1));
            chk(first == (heff > 0), "R6 restart at period start", {31'd0, first}, {31'd0, heff > 0});
            chk(pwm_out[3:1] == 3'b0, "R7 idle channels stay low", {29'd0, pwm_out[3:1]}, 32'd0);
            // stop request while running: waits for period end
            wr(5'd4, ctrl_word(1'b0, 1'b1, pre));
            rd(5'd4, rv);
            chk(rv[30] == 1'b1, "R5 commit bit pending", {31'd0, rv[30]}, 32'd1);
            chk(pwm_out[0] == (heff > 0), "R5 stop deferred to period end", {31'd0, pwm_out[0]}, {31'd0, heff > 0});
            repeat (n) @(negedge clk);
            chk(pwm_out[0] == 1'b0, "R6 stopped channel low", {31'd0, pwm_out[0]}, 32'd0);
            rd(5'd4, rv);
            chk(rv[30] == 1'b0, "R5 commit bit cleared", {31'd0, rv[30]}, 32'd0);
        end

        // R5 R4: commit on channel 1 waits for the period end
        wr(5'd8, {16'd1, 16'd3});
        wr(5'd12, ctrl_word(1'b1, 1'b1, 16'd0));
        @(negedge clk);
        chk(pwm_out[1] == 1'b1, "R6 channel 1 first cycle", {31'd0, pwm_out[1]}, 32'd1);
        wr(5'd8, {16'd3, 16'd3});
        wr(5'd12, ctrl_word(1'b1, 1'b1, 16'd0));
        rd(5'd12, rv);
        chk(rv == 32'hC000_0000, "R9 control readback with pending", rv, 32'hC000_0000);
        chk(pwm_out[1] == 1'b0, "R5 old high time still active", {31'd0, pwm_out[1]}, 32'd0);
        @(negedge clk);
        chk(pwm_out[1] == 1'b0, "R5 last cycle of old period", {31'd0, pwm_out[1]}, 32'd0);
        @(negedge clk);
        chk(pwm_out[1] == 1'b1, "R5 new high time in new period", {31'd0, pwm_out[1]}, 32'd1);
        rd(5'd12, rv);
        chk(rv[30] == 1'b0, "R5 commit done", {31'd0, rv[30]}, 32'd0);
        repeat (3) @(negedge clk);
        chk(pwm_out[1] == 1'b0, "R2 new compare at step 3", {31'd0, pwm_out[1]}, 32'd0);
        rd(5'd8, rv);
        chk(rv == 32'h0003_0003, "R9 timing readback", rv, 32'h0003_0003);

        // R4: writes without commit are ignored at the output (channel 2)
        wr(5'd16, {16'd1, 16'd1});
        wr(5'd20, ctrl_word(1'b1, 1'b1, 16'd0));
        @(negedge clk);
        wr(5'd16, {16'd0, 16'd1});
        wr(5'd20, ctrl_word(1'b0, 1'b0, 16'd0));
        begin
            int highs;
            highs = 0;
            for (int s = 0; s < 8; s++) begin
                @(negedge clk);
                if (pwm_out[2]) highs++;
            end
            chk(highs == 4, "R4 staged stop and high time not applied", highs, 4);
        end
        rd(5'd20, rv);
        chk(rv == 32'd0, "R9 staged control readback", rv, 32'd0);
        rd(5'd16, rv);
        chk(rv == 32'h0000_0001, "R1 timing fields of channel 2", rv, 32'h0000_0001);

        // R1: misaligned access writes nothing and reads 0
        wr(5'd17, 32'hFFFF_FFFF);
        rd(5'd16, rv);
        chk(rv == 32'h0000_0001, "R1 misaligned write ignored", rv, 32'h0000_0001);
        rd(5'd17, rv);
        chk(rv == 32'd0, "R1 misaligned read zero", rv, 32'd0);
        chk(pwm_out[3] == 1'b0, "R7 channel 3 untouched", {31'd0, pwm_out[3]}, 32'd0);

        // R8: reset during operation
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(pwm_out == 4'b0, "R8 outputs after mid-run reset", {28'd0, pwm_out}, 32'd0);
        rd(5'd8, rv);
        chk(rv == 32'd0, "R8 staged word after mid-run reset", rv, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule